// File: doc/BRIEF.md
# Timing PLL Operating-Mode Controller

This block chooses the operating state of a telecom timing DPLL. A two-bit mode select lets the user request normal tracking, manual holdover or freerun. Two more states are entered on their own while normal is requested. Automatic holdover covers a reference that a quality detector has flagged as bad. Short-time holdover covers a change on the reference-select input. The block also decides whether the phase-transient-elimination (TIE) stage is active.

The controller only moves when a frame-rate tick is present. The tick is an 8 kHz frame pulse, one clock wide. It drives a mode code to the DPLL loop, a TIE enable to the phase-alignment stage, and a state number for observation. The loop filter, the signal-quality detector and the TIE arithmetic are separate blocks.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset the state number is 0 (freerun), the DPLL mode code is 10 and the TIE enable is low.
- R2: State and TIE enable change only on a clock edge where `tick` is high. With `tick` low they hold, whatever the other inputs do.
- R3: On a tick, mode select 10 gives freerun (state 0) and mode select 01 gives manual holdover (state 3), from any state.
- R4: On a tick, mode select 11 (reserved) keeps the current state and TIE enable unchanged.
- R5: On a tick with mode select 00 and `ref_bad` high, the next state is auto-holdover (state 2) from any state. This holds even when a selection transient is present in the same tick.
- R6: On a tick with mode select 00 and `ref_bad` low, auto-holdover returns to normal (state 1).
- R7: A selection transient on a tick means `ref_sel` differs from the value it had at the previous tick. With mode select 00 and a valid reference, a transient moves normal to short-time holdover (state 4). Short-time holdover stays while transients continue. It returns to normal on the first tick without one.
- R8: On entry to normal from any other state, the TIE enable takes the value of `tie_req` at that tick.
- R9: Leaving normal for any other state clears the TIE enable. While the block stays in normal, changes on `tie_req` do not alter it.
- R10: The DPLL mode code is 00 in normal, 01 in states 2, 3 and 4, and 10 in freerun. It is never 11.
- R11: On a tick with mode select 00 and a valid reference, freerun and manual holdover move to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Frame-rate tick, one clock wide |
| mode_sel | input | 2 | Requested mode: 00 normal, 01 holdover, 10 freerun, 11 reserved |
| ref_sel | input | SEL_W | Reference-select value |
| ref_bad | input | 1 | High when the active reference is invalid |
| tie_req | input | 1 | Requests TIE when normal is entered |
| dpll_mode | output | 2 | Mode code to the DPLL loop |
| tie_en | output | 1 | Enable for the phase-alignment stage |
| state_num | output | 3 | Current state number 0..4 |

## Verification
The bench builds the block with `SEL_W` = 2. That selects the multi-bit comparison variant of the transient detector. It lets a chain of distinct selection codes produce back-to-back transients that keep the block in short-time holdover. A final code change lands in the same tick as a bad reference, which checks that auto-holdover wins.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

   localparam int STATE_W = 3;
   localparam int MODE_W  = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_FREERUN   = 3'd0,
      ST_NORMAL    = 3'd1,
      ST_AUTOHOLD  = 3'd2,
      ST_HOLD      = 3'd3,
      ST_SHORTHOLD = 3'd4
   } op_state_e;

   localparam logic [MODE_W-1:0] REQ_NORMAL   = 2'b00;
   localparam logic [MODE_W-1:0] REQ_HOLD     = 2'b01;
   localparam logic [MODE_W-1:0] REQ_FREERUN  = 2'b10;
   localparam logic [MODE_W-1:0] REQ_RESERVED = 2'b11;

   localparam logic [MODE_W-1:0] LOOP_TRACK   = 2'b00;
   localparam logic [MODE_W-1:0] LOOP_HOLD    = 2'b01;
   localparam logic [MODE_W-1:0] LOOP_FREE    = 2'b10;

endpackage

// File: rtl/pll_sel_watch.sv
module pll_sel_watch #(
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] ref_sel,
   output logic             transient
);

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (tick)
         sel_q <= ref_sel;
   end

   generate
      if (SEL_W == 1) begin : g_single
         assign transient = ref_sel[0] ^ sel_q[0];
      end else begin : g_multi
         assign transient = |(ref_sel ^ sel_q);
      end
   endgenerate

   // A held select never reports a transient on the following tick.
   AST_SEL_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      tick ##1 ($stable(ref_sel) && !tick) |-> !transient) else $error("sel watch"); // R7

endmodule

// File: rtl/pll_state_next.sv
module pll_state_next
   import pll_mode_pkg::*;
(
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              ref_bad,
   input  logic              transient,
   input  op_state_e         cur,
   output op_state_e         nxt
);

   always_comb begin
      nxt = cur;
      unique case (mode_sel)
         REQ_FREERUN:  nxt = ST_FREERUN;
         REQ_HOLD:     nxt = ST_HOLD;
         REQ_RESERVED: nxt = cur;
         default: begin
            if (ref_bad) begin
               nxt = ST_AUTOHOLD;
            end else begin
               unique case (cur)
                  ST_NORMAL:    nxt = transient ? ST_SHORTHOLD : ST_NORMAL;
                  ST_SHORTHOLD: nxt = transient ? ST_SHORTHOLD : ST_NORMAL;
                  default:      nxt = ST_NORMAL;
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/pll_state_reg.sv
module pll_state_reg
   import pll_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  op_state_e nxt,
   input  logic      tie_req,
   output op_state_e state,
   output logic      tie_en
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_FREERUN;
         tie_en <= 1'b0;
      end else if (tick) begin
         state <= nxt;
         if (nxt != ST_NORMAL)
            tie_en <= 1'b0;
         else if (state != ST_NORMAL)
            tie_en <= tie_req;
      end
   end

   AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(state) && $stable(tie_en)) else $error("tick gate"); // R2
   AST_TIE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      tie_en |-> state == ST_NORMAL) else $error("tie outside normal"); // R9
   AST_TIE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      tick && state != ST_NORMAL && nxt == ST_NORMAL |=> tie_en == $past(tie_req)) else $error("tie entry"); // R8

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
   import pll_mode_pkg::*;
#(
   parameter int SEL_W = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [MODE_W-1:0]  mode_sel,
   input  logic [SEL_W-1:0]   ref_sel,
   input  logic               ref_bad,
   input  logic               tie_req,
   output logic [MODE_W-1:0]  dpll_mode,
   output logic               tie_en,
   output logic [STATE_W-1:0] state_num
);

   generate
      if (SEL_W < 1 || SEL_W > 16) begin : g_bad_width
         $error("pll_mode_ctrl: SEL_W must be 1..16");
      end
   endgenerate

   logic      transient;
   op_state_e nxt;
   op_state_e state;

   pll_sel_watch #(.SEL_W(SEL_W)) u_watch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ref_sel(ref_sel), .transient(transient)
   );

   pll_state_next u_next (
      .mode_sel(mode_sel), .ref_bad(ref_bad), .transient(transient), .cur(state), .nxt(nxt)
   );

   pll_state_reg u_reg (
      .clk(clk), .rst_n(rst_n), .tick(tick), .nxt(nxt), .tie_req(tie_req),
      .state(state), .tie_en(tie_en)
   );

   always_comb begin
      unique case (state)
         ST_NORMAL:  dpll_mode = LOOP_TRACK;
         ST_FREERUN: dpll_mode = LOOP_FREE;
         default:    dpll_mode = LOOP_HOLD;
      endcase
   end

   assign state_num = STATE_W'(state);

   AST_FORCE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      tick && mode_sel == REQ_FREERUN |=> state_num == 3'd0) else $error("freerun"); // R3
   AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tick && mode_sel == REQ_RESERVED |=> $stable(state_num) && $stable(tie_en)) else $error("reserved"); // R4
   AST_BAD_REF: assert property (@(posedge clk) disable iff (!rst_n)
      tick && mode_sel == REQ_NORMAL && ref_bad |=> state_num == 3'd2) else $error("bad ref"); // R5
   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      dpll_mode != 2'b11 && state_num <= 3'd4) else $error("code"); // R10

endmodule

// File: tb/pll_mode_ctrl_test.sv
module pll_mode_ctrl_test;

   localparam int SW = 2;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [1:0]    mode_sel = 2'b10;
   logic [SW-1:0] ref_sel = '0;
   logic          ref_bad = 1'b0;
   logic          tie_req = 1'b0;
   logic [1:0]    dpll_mode;
   logic          tie_en;
   logic [2:0]    state_num;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pll_mode_ctrl #(.SEL_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel), .ref_sel(ref_sel),
      .ref_bad(ref_bad), .tie_req(tie_req), .dpll_mode(dpll_mode), .tie_en(tie_en),
      .state_num(state_num)
   );

   // entry: mode(2) sel(2) bad(1) treq(1) exp_state(3) exp_tie(1)
   localparam logic [9:0] VEC [NV] = '{
      {2'b10, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0},  // R3 freerun
      {2'b00, 2'd0, 1'b0, 1'b1, 3'd1, 1'b1},  // R11 R8
      {2'b00, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1},  // R9 hold in normal
      {2'b00, 2'd1, 1'b0, 1'b1, 3'd4, 1'b0},  // R7 transient
      {2'b00, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0},  // R7 repeated transient
      {2'b00, 2'd2, 1'b0, 1'b0, 3'd1, 1'b0},  // R7 R8 back, req low
      {2'b00, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0},  // R5
      {2'b00, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0},  // R5 stays
      {2'b00, 2'd2, 1'b0, 1'b1, 3'd1, 1'b1},  // R6 R8
      {2'b00, 2'd3, 1'b1, 1'b1, 3'd2, 1'b0},  // R5 priority over transient
      {2'b00, 2'd3, 1'b0, 1'b1, 3'd1, 1'b1},  // R6
      {2'b11, 2'd0, 1'b1, 1'b0, 3'd1, 1'b1},  // R4 reserved
      {2'b01, 2'd0, 1'b0, 1'b0, 3'd3, 1'b0},  // R3 manual holdover
      {2'b11, 2'd0, 1'b0, 1'b1, 3'd3, 1'b0},  // R4 reserved
      {2'b00, 2'd0, 1'b0, 1'b0, 3'd1, 1'b0},  // R11 from holdover
      {2'b10, 2'd0, 1'b0, 1'b1, 3'd0, 1'b0},  // R3 R9 leave normal
      {2'b00, 2'd0, 1'b1, 1'b1, 3'd2, 1'b0}   // R5 from freerun
   };

   function automatic logic [1:0] exp_code(input logic [2:0] st);
      if (st == 3'd1)      return 2'b00;
      else if (st == 3'd0) return 2'b10;
      else                 return 2'b01;
   endfunction

   task automatic check(input string req, input logic [2:0] est, input logic etie);
      checks++;
      if (state_num !== est || tie_en !== etie || dpll_mode !== exp_code(est)) begin
         fails++;
         $display("FAIL %s: state=%0d tie=%0b code=%b expected state=%0d tie=%0b code=%b",
                  req, state_num, tie_en, dpll_mode, est, etie, exp_code(est));
      end
   endtask

   task automatic step(input logic [1:0] m, input logic [SW-1:0] s, input logic b, input logic t);
      @(negedge clk);
      mode_sel = m; ref_sel = s; ref_bad = b; tie_req = t; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 3'd0, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][9:8], VEC[i][7:6], VEC[i][5], VEC[i][4]);
         check($sformatf("R10 vector %0d", i), VEC[i][3:1], VEC[i][0]);
      end
      // R2: go to normal with TIE high, then toggle inputs without tick
      step(2'b00, 2'd0, 1'b0, 1'b1);
      check("R6 setup", 3'd1, 1'b1);
      @(negedge clk);
      mode_sel = 2'b10; ref_bad = 1'b1; ref_sel = 2'd3; tie_req = 1'b0;
      repeat (5) @(negedge clk);
      check("R2 no tick", 3'd1, 1'b1);
      // R9: tie_req toggle while staying in normal
      step(2'b00, 2'd3, 1'b0, 1'b0);
      check("R7 R9 transient leaves normal", 3'd4, 1'b0);
      step(2'b00, 2'd3, 1'b0, 1'b1);
      check("R8 re-entry", 3'd1, 1'b1);
      step(2'b00, 2'd3, 1'b0, 1'b0);
      check("R9 req ignored in normal", 3'd1, 1'b1);
      // R1: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset again", 3'd0, 1'b0);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule